// File: doc/BRIEF.md
# Dynamic Over-Current Limit Sequencer

This block keeps the over-current limit for one channel of a high-side load switch. When the channel turns on, the limit starts at its highest level so that a lamp filament or a motor can take its inrush current. It then steps down through a fixed schedule, measured in millisecond ticks, until it reaches a steady low level chosen by software. A configuration bit picks a lamp or a motor timing profile. A second bit picks one of two sense ranges, and each range has its own table of limits.

Every clock cycle, a digitised load-current sample is compared against the active limit. A sample above the limit sets a sticky fault. The fault drives an active-low status flag and a shutdown request to the gate drive. The fault can be cleared only while the channel is commanded off. A device with two channels uses one instance per channel, and each instance has its own profile input.

Top module: `ocp_profile_ctrl`

## Requirements
- R1: After reset, the threshold code is the top level of the selected range, and fault=0, fault_n=1, shutdown=0.
- R2: While ch_on=0, the schedule is held at the top level. Ticks do not move it, and thr_code shows the top level of the selected range.
- R3: With profile_motor=0 and the channel on, the limit levels last for these numbers of ticks, counted from turn-on: level 0 for 9, level 1 for 17, level 2 for 67 and level 3 for 137. After that, the final level applies.
- R4: With profile_motor=1, levels 0 and 1 keep the lengths given in R3. Level 2 lasts 214 ticks and level 3 lasts 429 ticks.
- R5: The final level comes from final_sel. A value of 0 selects level 4, 1 selects level 5, and 2 or 3 selects level 6.
- R6: thr_code is a 12-bit value in 50 mA units. With range_low=0, levels 0..6 are 2200, 1400, 866, 534, 360, 240 and 120. With range_low=1 they are 734, 466, 288, 178, 120, 80 and 40.
- R7: While ch_on=1, a sample strictly greater than thr_code sets the fault at the next clock edge. A sample equal to thr_code does not set it, and no sample sets it while ch_on=0.
- R8: Once set, the fault stays set. A clr_fault pulse while ch_on=1 is ignored. A clr_fault pulse while ch_on=0 clears the fault at the next edge.
- R9: fault_n is always the inverse of fault, and shutdown always equals fault.
- R10: Every turn-on restarts the schedule at level 0. This holds even when the channel was off for a single cycle.
- R11: The schedule advances only on cycles where tick_ms=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_on | input | 1 | Channel on command |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| sample | input | 12 | Load current, in 50 mA units |
| profile_motor | input | 1 | 0 = lamp timing, 1 = motor timing |
| range_low | input | 1 | 0 = high sense range, 1 = low sense range |
| final_sel | input | 2 | Selects the steady-state low level |
| clr_fault | input | 1 | Fault clear strobe, honoured only while off |
| thr_code | output | 12 | Active threshold code |
| fault | output | 1 | Sticky over-current fault |
| fault_n | output | 1 | Active-low fault status |
| shutdown | output | 1 | Request to switch the channel off |

## Verification
The hardest state to reach is the motor profile's final level. It lies more than 660 ticks after turn-on, and it must be reached without an off cycle or a stopped tick disturbing the count. The stimulus holds the channel on and pulses the tick on every clock for that whole stretch. To test the strict comparison, the stimulus also stops the tick so that the level cannot move. It then places the sample exactly on the active code and one step above it.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int CODE_W = 12;
  localparam int LVL_W  = 3;

  typedef enum logic [2:0] {
    STG_H1  = 3'd0,
    STG_H2  = 3'd1,
    STG_M1  = 3'd2,
    STG_M2  = 3'd3,
    STG_LOW = 3'd4
  } stage_e;

  // Level index (0 = highest) for a stage and a final-level field.
  function automatic logic [LVL_W-1:0] stage_level(input stage_e s, input logic [1:0] sel);
    logic [LVL_W-1:0] lvl;
    if (s != STG_LOW) lvl = LVL_W'(s);
    else if (sel >= 2'd2) lvl = 3'd6;
    else lvl = 3'd4 + LVL_W'(sel);
    return lvl;
  endfunction

  // Threshold code in 50 mA units for a level in a sense range.
  function automatic logic [CODE_W-1:0] level_code(input logic low_rng, input logic [LVL_W-1:0] lvl);
    logic [CODE_W-1:0] c;
    if (!low_rng) begin
      case (lvl)
        3'd0: c = 12'd2200;
        3'd1: c = 12'd1400;
        3'd2: c = 12'd866;
        3'd3: c = 12'd534;
        3'd4: c = 12'd360;
        3'd5: c = 12'd240;
        default: c = 12'd120;
      endcase
    end else begin
      case (lvl)
        3'd0: c = 12'd734;
        3'd1: c = 12'd466;
        3'd2: c = 12'd288;
        3'd3: c = 12'd178;
        3'd4: c = 12'd120;
        3'd5: c = 12'd80;
        default: c = 12'd40;
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/ocp_stage_seq.sv
module ocp_stage_seq
  import ocp_pkg::*;
#(
  parameter int H1_TICKS  = 9,
  parameter int H2_TICKS  = 17,
  parameter int LM1_TICKS = 67,
  parameter int LM2_TICKS = 137,
  parameter int MM1_TICKS = 214,
  parameter int MM2_TICKS = 429
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ch_on,
  input  logic   tick_ms,
  input  logic   profile_motor,
  output stage_e stage
);
  localparam int MAX_TICKS = (MM2_TICKS > LM2_TICKS) ? MM2_TICKS : LM2_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] cur_len;
  logic             stage_done;

  always_comb begin
    case (stage)
      STG_H1:  cur_len = CNT_W'(H1_TICKS);
      STG_H2:  cur_len = CNT_W'(H2_TICKS);
      STG_M1:  cur_len = profile_motor ? CNT_W'(MM1_TICKS) : CNT_W'(LM1_TICKS);
      STG_M2:  cur_len = profile_motor ? CNT_W'(MM2_TICKS) : CNT_W'(LM2_TICKS);
      default: cur_len = '0;
    endcase
  end

  assign cnt_nxt    = cnt_q + 1'b1;
  assign stage_done = (cnt_nxt >= cur_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= STG_H1;
      cnt_q <= '0;
    end else if (!ch_on) begin
      stage <= STG_H1;
      cnt_q <= '0;
    end else if (tick_ms && stage != STG_LOW) begin
      if (stage_done) begin
        stage <= stage_e'(stage + 3'd1);
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/ocp_thr_select.sv
module ocp_thr_select
  import ocp_pkg::*;
(
  input  stage_e            stage,
  input  logic              range_low,
  input  logic [1:0]        final_sel,
  output logic [LVL_W-1:0]  level,
  output logic [CODE_W-1:0] thr_code
);
  assign level    = stage_level(stage, final_sel);
  assign thr_code = level_code(range_low, level);
endmodule

// File: rtl/ocp_fault_latch.sv
module ocp_fault_latch
  import ocp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_on,
  input  logic              clr_fault,
  input  logic [CODE_W-1:0] sample,
  input  logic [CODE_W-1:0] thr_code,
  output logic              over_ev,
  output logic              fault_q
);
  assign over_ev = ch_on && (sample > thr_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  fault_q <= 1'b0;
    else if (over_ev)            fault_q <= 1'b1;
    else if (!ch_on && clr_fault) fault_q <= 1'b0;
  end
endmodule

// File: rtl/ocp_profile_ctrl.sv
module ocp_profile_ctrl
  import ocp_pkg::*;
#(
  parameter int H1_TICKS  = 9,
  parameter int H2_TICKS  = 17,
  parameter int LM1_TICKS = 67,
  parameter int LM2_TICKS = 137,
  parameter int MM1_TICKS = 214,
  parameter int MM2_TICKS = 429
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ch_on,
  input  logic        tick_ms,
  input  logic [11:0] sample,
  input  logic        profile_motor,
  input  logic        range_low,
  input  logic [1:0]  final_sel,
  input  logic        clr_fault,
  output logic [11:0] thr_code,
  output logic        fault,
  output logic        fault_n,
  output logic        shutdown
);
  stage_e             stage_idx;
  logic [LVL_W-1:0]   level_idx;
  logic               over_ev;
  logic               fault_q;

  ocp_stage_seq #(
    .H1_TICKS(H1_TICKS), .H2_TICKS(H2_TICKS),
    .LM1_TICKS(LM1_TICKS), .LM2_TICKS(LM2_TICKS),
    .MM1_TICKS(MM1_TICKS), .MM2_TICKS(MM2_TICKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .ch_on(ch_on), .tick_ms(tick_ms),
    .profile_motor(profile_motor), .stage(stage_idx)
  );

  ocp_thr_select u_thr (
    .stage(stage_idx), .range_low(range_low), .final_sel(final_sel),
    .level(level_idx), .thr_code(thr_code)
  );

  ocp_fault_latch u_flt (
    .clk(clk), .rst_n(rst_n), .ch_on(ch_on), .clr_fault(clr_fault),
    .sample(sample), .thr_code(thr_code), .over_ev(over_ev), .fault_q(fault_q)
  );

  assign fault    = fault_q;
  assign fault_n  = ~fault_q;
  assign shutdown = fault_q;
endmodule

// File: rtl/ocp_profile_chk.sv
module ocp_profile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ch_on,
  input logic        tick_ms,
  input logic        clr_fault,
  input logic [11:0] sample,
  input logic [11:0] thr_code,
  input logic        fault,
  input logic        fault_n,
  input logic [2:0]  stage_idx,
  input logic        over_ev
);
  assert_off_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_on |=> stage_idx == 3'd0);

  assert_stage_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ch_on |=> (stage_idx >= $past(stage_idx)));

  assert_no_tick_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_on && !tick_ms) |=> $stable(stage_idx));

  assert_over_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_on && sample > thr_code) |=> fault);

  assert_rise_needs_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(ch_on));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && ch_on) |=> fault);

  assert_clear_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_on && clr_fault) |=> !fault);

  assert_flag_polarity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_n != fault);

  assert_event_only_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    over_ev |-> ch_on);
endmodule

bind ocp_profile_ctrl ocp_profile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ch_on(ch_on), .tick_ms(tick_ms),
  .clr_fault(clr_fault), .sample(sample), .thr_code(thr_code),
  .fault(fault), .fault_n(fault_n), .stage_idx(stage_idx), .over_ev(over_ev)
);

// File: tb/ocp_profile_ctrl_bench.sv
`timescale 1ns/1ps
module ocp_profile_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ch_on = 1'b0;
  logic        tick_ms = 1'b0;
  logic [11:0] sample = '0;
  logic        profile_motor = 1'b0;
  logic        range_low = 1'b0;
  logic [1:0]  final_sel = 2'd0;
  logic        clr_fault = 1'b0;
  logic [11:0] thr_code;
  logic        fault, fault_n, shutdown;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  int m_t = 0;
  bit m_f = 0;

  int hi_tab[7] = '{2200, 1400, 866, 534, 360, 240, 120};
  int lo_tab[7] = '{734, 466, 288, 178, 120, 80, 40};

  always #5 clk = ~clk;

  ocp_profile_ctrl u_ocp_profile_ctrl (
    .clk(clk), .rst_n(rst_n), .ch_on(ch_on), .tick_ms(tick_ms),
    .sample(sample), .profile_motor(profile_motor), .range_low(range_low),
    .final_sel(final_sel), .clr_fault(clr_fault), .thr_code(thr_code),
    .fault(fault), .fault_n(fault_n), .shutdown(shutdown)
  );

  function automatic int exp_thr(int t);
    int m1 = profile_motor ? 214 : 67;
    int m2 = profile_motor ? 429 : 137;
    int lvl;
    if (t < 9) lvl = 0;
    else if (t < 26) lvl = 1;
    else if (t < 26 + m1) lvl = 2;
    else if (t < 26 + m1 + m2) lvl = 3;
    else lvl = (final_sel == 2'd0) ? 4 : (final_sel == 2'd1) ? 5 : 6;
    return range_low ? lo_tab[lvl] : hi_tab[lvl];
  endfunction

  // Behavioural reference: time since turn-on and the sticky flag.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_t = 0;
      m_f = 0;
    end else begin
      if (ch_on && int'(sample) > exp_thr(m_t)) m_f = 1;
      else if (!ch_on && clr_fault) m_f = 0;
      if (!ch_on) m_t = 0;
      else if (tick_ms && m_t < 100000) m_t = m_t + 1;
    end
  end

  task automatic check(string req, int act, int expv, string what);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at t=%0t", req, what, act, expv, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!done) begin
      check(cur_req, int'(thr_code), exp_thr(m_t), "thr_code");
      check(cur_req, int'(fault), int'(m_f), "fault");
      check("R9", int'(fault_n), int'(!m_f), "fault_n");
      check("R9", int'(shutdown), int'(m_f), "shutdown");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cur_req = "R1";
    run(3);
    rst_n = 1'b1;
    run(3);

    cur_req = "R2";
    tick_ms = 1'b1;
    run(10);
    range_low = 1'b1;
    run(10);
    range_low = 1'b0;

    cur_req = "R3";
    ch_on = 1'b1;
    run(245);

    cur_req = "R11";
    ch_on = 1'b0; run(1); ch_on = 1'b1;
    run(12);
    tick_ms = 1'b0;
    run(30);
    tick_ms = 1'b1;
    run(240);

    cur_req = "R5";
    final_sel = 2'd1; run(5);
    final_sel = 2'd2; run(5);
    final_sel = 2'd3; run(5);
    final_sel = 2'd0; run(5);

    cur_req = "R6";
    range_low = 1'b1;
    ch_on = 1'b0; run(2); ch_on = 1'b1;
    run(240);
    final_sel = 2'd1; run(3);
    final_sel = 2'd2; run(3);

    cur_req = "R10";
    ch_on = 1'b0; run(1); ch_on = 1'b1;
    run(15);
    range_low = 1'b0;
    final_sel = 2'd0;

    cur_req = "R4";
    ch_on = 1'b0; profile_motor = 1'b1; run(2); ch_on = 1'b1;
    run(680);
    final_sel = 2'd2; run(3);

    cur_req = "R7";
    ch_on = 1'b0; sample = 12'hFFF; run(5);
    ch_on = 1'b1; tick_ms = 1'b0;
    sample = 12'(exp_thr(m_t)); run(5);
    tick_ms = 1'b1; run(20); tick_ms = 1'b0;
    sample = 12'(exp_thr(m_t)); run(4);
    sample = 12'(exp_thr(m_t) + 1); run(4);
    sample = '0;

    cur_req = "R8";
    clr_fault = 1'b1; run(4); clr_fault = 1'b0;
    run(3);
    ch_on = 1'b0; sample = 12'hFFF; run(3);
    clr_fault = 1'b1; run(1); clr_fault = 1'b0;
    run(3);
    sample = '0; tick_ms = 1'b1;
    ch_on = 1'b1; run(10);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule